// File: doc/BRIEF.md
# Converter Bus Control Logic

This block is the processor-facing control section of a 12-bit successive-approximation converter. It watches a small set of bus control lines: a chip enable, an active-low chip select, a read/convert select, a byte address bit and a word-format strap. When a qualified command arrives, it does one of two things. It either sends a one-cycle start request, carrying a length flag, to the conversion sequencer, or it enables the data outputs in the format that was selected. A status line stays high for as long as a conversion is running. While that line is high, further convert commands are ignored and the outputs are held disabled. When the sequencer reports completion, the block keeps the result in a holding register so that it can be read many times.

The output drivers are modelled as a 12-bit data bus plus two enables. One enable covers the eight most significant result bits. The other covers the four least significant bits followed by four zeros. In byte mode, both bytes are presented left-justified on lanes 11..4. The bus inputs are asynchronous to the block clock, so they pass through a synchronizer whose depth is set by a parameter before they are decoded.

The block can also run in a stand-alone arrangement. In that case chip enable and the word strap are tied high, and chip select and the address bit are tied low. The read/convert line alone then controls the block: its falling edge starts a conversion, and the outputs are enabled while it is high.

Top module: `conv_bus_ctrl`

## Requirements
- R1: A command is qualified only while chip_en = 1 and chip_sel_n = 0. Without qualification there is no conversion start and both enables stay 0.
- R2: The edge where qualified rd_cvt = 0 begins produces a conv_start pulse exactly one cycle wide. conv_short shows the address bit sampled at that start: 0 requests the full 12-bit conversion and 1 requests the short 8-bit conversion. A bus change reaches the outputs after SYNC_STAGES + 1 clock edges.
- R3: busy rises in the same cycle as conv_start. It falls in the cycle after seq_done is seen high while busy.
- R4: A convert command that arrives while busy is high is ignored. A convert level held through the end of busy does not start a new conversion; a fresh qualifying edge is required.
- R5: Both output enables are 0 in every cycle in which busy is 1.
- R6: In word mode (word_mode = 1), a qualified read with rd_cvt = 1 asserts both enables, and data_out carries the whole held result.
- R7: In byte mode with address bit 0, only oe_msb is asserted. data_out[11:4] carries result bits 11..4 and data_out[3:0] is 0. The two enables are never both 1 in byte mode.
- R8: In byte mode with address bit 1, only oe_lsb is asserted. data_out[11:8] carries result bits 3..0, and data_out[7:0] is 0.
- R9: The byte selection is sampled when a read begins. A change of the address bit during that read has no effect on the enables or the data.
- R10: The result of a short conversion is stored with its four least significant bits forced to 0.
- R11: In the stand-alone tie-off, the outputs are enabled while rd_cvt is high, and a falling edge of rd_cvt starts a conversion. With a low pulse, the outputs turn off and come back with the new result once the conversion completes. With a high pulse, the outputs stay off after the conversion until rd_cvt rises again.
- R12: data_out is 0 whenever both enables are 0. A seq_done that arrives while busy is 0 leaves the held result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_cvt | input | 1 | 1 selects a read, 0 selects a convert |
| addr_lo | input | 1 | Byte address bit; on a convert start, selects the conversion length |
| word_mode | input | 1 | Format strap: 1 for a single 12-bit word, 0 for two bytes |
| seq_done | input | 1 | End-of-conversion pulse from the sequencer |
| seq_result | input | 12 | Conversion result from the sequencer, valid with seq_done |
| conv_start | output | 1 | One-cycle start request to the sequencer |
| conv_short | output | 1 | Length of the latest start: 1 means the short conversion |
| busy | output | 1 | Conversion-in-progress status |
| data_out | output | 12 | Output data lanes |
| oe_msb | output | 1 | Enable for the most-significant-byte drivers |
| oe_lsb | output | 1 | Enable for the least-significant-nibble-plus-zeros drivers |

## Verification
The hardest case to reach is a convert command that shows up while a conversion is already running, together with a convert level that is still held when busy drops. Either one could produce a second start if the edge detector were wrong. The bench makes the sequencer response slow, toggles chip select so that a fresh qualified edge appears mid-conversion, and keeps the convert level asserted across completion. It then checks that the number of start pulses and the busy line are unchanged. A reference model runs cycle by cycle with the same synchronizer delay and is compared on every clock. It covers both stand-alone pulse shapes, and it covers an address change in the middle of a byte read.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

   // Bus control lines bundled so they can share one synchronizer.
   typedef struct packed {
      logic ce;
      logic cs_n;
      logic rc;
      logic a0;
      logic word;
   } bus_pins_t;

   localparam int BUS_PINS_W = $bits(bus_pins_t);

endpackage

// File: rtl/cbc_sync.sv
module cbc_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 0) begin : g_bad_stages
      $error("cbc_sync: STAGES must be zero or positive");
   end
   if (W < 1) begin : g_bad_width
      $error("cbc_sync: W must be at least one");
   end

   if (STAGES == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_chain
      logic [W-1:0] chain [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
         end else begin
            chain[0] <= din;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
         end
      end

      assign dout = chain[STAGES-1];
   end

endmodule

// File: rtl/cbc_cmd_ctrl.sv
module cbc_cmd_ctrl #(
   parameter int RES_W   = 12,
   parameter int SHORT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qual,
   input  logic             rc,
   input  logic             a0,
   input  logic             seq_done,
   input  logic [RES_W-1:0] seq_result,
   output logic             conv_start,
   output logic             conv_short,
   output logic             busy,
   output logic [RES_W-1:0] hold
);

   localparam int DROP_W = RES_W - SHORT_W;

   if (SHORT_W < 1 || SHORT_W >= RES_W) begin : g_bad_short
      $error("cbc_cmd_ctrl: SHORT_W must lie between 1 and RES_W-1");
   end

   function automatic logic [RES_W-1:0] keep_mask();
      logic [RES_W-1:0] m;
      for (int i = 0; i < RES_W; i++) m[i] = (i >= DROP_W);
      return m;
   endfunction

   localparam logic [RES_W-1:0] SHORT_KEEP = keep_mask();

   logic             cvt_lvl, cvt_lvl_d, cvt_edge, accept, retire;
   logic             start_q, short_q, busy_q;
   logic [RES_W-1:0] hold_q;

   assign cvt_lvl  = qual & ~rc;
   assign cvt_edge = cvt_lvl & ~cvt_lvl_d;
   assign accept   = cvt_edge & ~busy_q;
   assign retire   = busy_q & seq_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cvt_lvl_d <= 1'b0;
         start_q   <= 1'b0;
         short_q   <= 1'b0;
         busy_q    <= 1'b0;
         hold_q    <= '0;
      end else begin
         cvt_lvl_d <= cvt_lvl;
         start_q   <= accept;
         if (accept) short_q <= a0;
         if (accept)      busy_q <= 1'b1;
         else if (retire) busy_q <= 1'b0;
         if (retire) hold_q <= short_q ? (seq_result & SHORT_KEEP) : seq_result;
      end
   end

   assign conv_start = start_q;
   assign conv_short = short_q;
   assign busy       = busy_q;
   assign hold       = hold_q;

   // R2 / R3: a start pulse coincides with busy rising from low
   assert_start_raises_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (busy_q && !$past(busy_q)));

   // R3: busy only drops after the sequencer reported completion
   assert_busy_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(seq_done));

endmodule

// File: rtl/cbc_read_path.sv
module cbc_read_path #(
   parameter int RES_W  = 12,
   parameter int BYTE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qual,
   input  logic             rc,
   input  logic             a0,
   input  logic             word,
   input  logic             busy,
   input  logic [RES_W-1:0] hold,
   output logic [RES_W-1:0] data_out,
   output logic             oe_msb,
   output logic             oe_lsb
);

   localparam int LSB_W = RES_W - BYTE_W;
   localparam int PAD_W = BYTE_W - LSB_W;

   if (LSB_W < 1 || LSB_W > BYTE_W) begin : g_bad_split
      $error("cbc_read_path: RES_W must exceed BYTE_W and be at most twice it");
   end

   logic [RES_W-1:0] msb_word, lsb_word;

   // Left-justified byte images on lanes RES_W-1 .. LSB_W
   assign msb_word = {hold[RES_W-1 -: BYTE_W], {LSB_W{1'b0}}};

   if (PAD_W > 0) begin : g_pad
      assign lsb_word = {hold[LSB_W-1:0], {PAD_W{1'b0}}, {LSB_W{1'b0}}};
   end else begin : g_nopad
      assign lsb_word = {hold[LSB_W-1:0], {LSB_W{1'b0}}};
   end

   logic             rd_lvl, rd_on, sel_q, sel_now;
   logic             oe_msb_q, oe_lsb_q;
   logic [RES_W-1:0] data_q;

   assign rd_lvl  = qual & rc & ~busy;
   assign sel_now = rd_on ? sel_q : a0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_on    <= 1'b0;
         sel_q    <= 1'b0;
         oe_msb_q <= 1'b0;
         oe_lsb_q <= 1'b0;
         data_q   <= '0;
      end else begin
         rd_on    <= rd_lvl;
         sel_q    <= sel_now;
         oe_msb_q <= rd_lvl & (word | ~sel_now);
         oe_lsb_q <= rd_lvl & (word | sel_now);
         if (!rd_lvl)     data_q <= '0;
         else if (word)   data_q <= hold;
         else if (sel_now) data_q <= lsb_word;
         else             data_q <= msb_word;
      end
   end

   assign data_out = data_q;
   assign oe_msb   = oe_msb_q;
   assign oe_lsb   = oe_lsb_q;

   // R5: no driver enabled while a conversion runs
   assert_oe_off_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(oe_msb_q || oe_lsb_q));

   // R7: both enables together only when the strap selected word format
   assert_byte_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_msb_q && oe_lsb_q) |-> $past(word));

   // R9: a byte read never switches lanes without going idle first
   assert_lane_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_msb_q ^ oe_lsb_q) |=> (!(oe_msb_q ^ oe_lsb_q) || (oe_msb_q == $past(oe_msb_q))));

endmodule

// File: rtl/conv_bus_ctrl.sv
module conv_bus_ctrl #(
   parameter int RES_W       = 12,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_en,
   input  logic             chip_sel_n,
   input  logic             rd_cvt,
   input  logic             addr_lo,
   input  logic             word_mode,
   input  logic             seq_done,
   input  logic [RES_W-1:0] seq_result,
   output logic             conv_start,
   output logic             conv_short,
   output logic             busy,
   output logic [RES_W-1:0] data_out,
   output logic             oe_msb,
   output logic             oe_lsb
);
   import cbc_pkg::*;

   bus_pins_t        pins_raw, pins_s;
   logic             qual;
   logic [RES_W-1:0] hold;

   always_comb begin
      pins_raw.ce   = chip_en;
      pins_raw.cs_n = chip_sel_n;
      pins_raw.rc   = rd_cvt;
      pins_raw.a0   = addr_lo;
      pins_raw.word = word_mode;
   end

   cbc_sync #(.STAGES(SYNC_STAGES), .W(BUS_PINS_W)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pins_raw),
      .dout (pins_s)
   );

   assign qual = pins_s.ce & ~pins_s.cs_n;

   cbc_cmd_ctrl #(.RES_W(RES_W), .SHORT_W(BYTE_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual      (qual),
      .rc        (pins_s.rc),
      .a0        (pins_s.a0),
      .seq_done  (seq_done),
      .seq_result(seq_result),
      .conv_start(conv_start),
      .conv_short(conv_short),
      .busy      (busy),
      .hold      (hold)
   );

   cbc_read_path #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .qual    (qual),
      .rc      (pins_s.rc),
      .a0      (pins_s.a0),
      .word    (pins_s.word),
      .busy    (busy),
      .hold    (hold),
      .data_out(data_out),
      .oe_msb  (oe_msb),
      .oe_lsb  (oe_lsb)
   );

endmodule

// File: tb/conv_bus_ctrl_test.sv
`timescale 1ns/1ps
module conv_bus_ctrl_test;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_en = 1'b0, chip_sel_n = 1'b1, rd_cvt = 1'b1, addr_lo = 1'b0, word_mode = 1'b1;
   logic seq_done = 1'b0;
   logic [11:0] seq_result = '0;
   logic conv_start, conv_short, busy, oe_msb, oe_lsb;
   logic [11:0] data_out;

   always #2 clk = ~clk;

   conv_bus_ctrl uut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
      .rd_cvt(rd_cvt), .addr_lo(addr_lo), .word_mode(word_mode),
      .seq_done(seq_done), .seq_result(seq_result),
      .conv_start(conv_start), .conv_short(conv_short), .busy(busy),
      .data_out(data_out), .oe_msb(oe_msb), .oe_lsb(oe_lsb)
   );

   int checks = 0;
   int errors = 0;
   int starts = 0;
   bit finished = 0;
   string cur_req = "R1";

   int resp_lat = 6;
   bit auto_resp = 1;
   logic [11:0] next_res = '0;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Reference model: behavioural, cycle by cycle
   logic [4:0] hist[$];
   int m_start, m_short, m_busy, m_hold, m_cvtd, m_rdon, m_sel, m_oem, m_oel, m_data;
   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         m_start = 0; m_short = 0; m_busy = 0; m_hold = 0; m_cvtd = 0;
         m_rdon = 0; m_sel = 0; m_oem = 0; m_oel = 0; m_data = 0;
      end else begin
         logic [4:0] s;
         int qual, rc, a0, wd, cq, acc, ret, rdq, nsel, ndata, nhold;
         hist.push_back({chip_en, chip_sel_n, rd_cvt, addr_lo, word_mode});
         s = (hist.size() > SYNC) ? hist[hist.size()-1-SYNC] : 5'b0;
         if (hist.size() > 8) void'(hist.pop_front());
         qual = (s[4] && !s[3]) ? 1 : 0;
         rc = s[2]; a0 = s[1]; wd = s[0];
         cq   = (qual && !rc) ? 1 : 0;
         acc  = (cq && !m_cvtd && !m_busy) ? 1 : 0;
         ret  = (m_busy && seq_done) ? 1 : 0;
         rdq  = (qual && rc && !m_busy) ? 1 : 0;
         nsel = m_rdon ? m_sel : a0;
         if (!rdq) ndata = 0;
         else if (wd) ndata = m_hold;
         else if (nsel) ndata = (m_hold & 'hF) << 8;
         else ndata = m_hold & 'hFF0;
         nhold = m_hold;
         if (ret) nhold = m_short ? (int'(seq_result) & 'hFF0) : int'(seq_result);
         m_oem = (rdq && (wd || !nsel)) ? 1 : 0;
         m_oel = (rdq && (wd || nsel)) ? 1 : 0;
         m_data = ndata;
         m_hold = nhold;
         m_start = acc;
         if (acc) m_short = a0;
         if (acc) m_busy = 1; else if (ret) m_busy = 0;
         m_cvtd = cq; m_rdon = rdq; m_sel = nsel;
      end
   end

   // Compare every cycle away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(cur_req, "conv_start", conv_start, m_start);
         chk(cur_req, "conv_short", conv_short, m_short);
         chk(cur_req, "busy", busy, m_busy);
         chk(cur_req, "oe_msb", oe_msb, m_oem);
         chk(cur_req, "oe_lsb", oe_lsb, m_oel);
         chk(cur_req, "data_out", data_out, m_data);
         if (conv_start) starts++;
      end
   end

   // Sequencer stand-in
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && conv_start && auto_resp) begin
            repeat (resp_lat - 1) @(negedge clk);
            seq_result = next_res;
            seq_done = 1'b1;
            @(negedge clk);
            seq_done = 1'b0;
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus(logic ce, logic csn, logic rc, logic a, logic w);
      chip_en = ce; chip_sel_n = csn; rd_cvt = rc; addr_lo = a; word_mode = w;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      cur_req = "R3";
      chk("R3", "reset busy", busy, 0);
      chk("R12", "reset data", data_out, 0);
      chk("R1", "reset enables", {oe_msb, oe_lsb}, 0);

      // Full conversion then word read
      cur_req = "R2";
      next_res = 12'hA5C;
      bus(1, 0, 0, 0, 1); tick(3);
      bus(0, 1, 1, 0, 1); tick(20);
      chk("R2", "start count full", starts, 1);
      cur_req = "R6";
      bus(1, 0, 1, 0, 1); tick(6);
      chk("R6", "word enables", {oe_msb, oe_lsb}, 3);
      chk("R6", "word data", data_out, 'hA5C);
      bus(0, 1, 1, 0, 1); tick(6);
      chk("R12", "idle data", data_out, 0);

      // Byte reads
      cur_req = "R7";
      bus(1, 0, 1, 0, 0); tick(6);
      chk("R7", "msb enables", {oe_msb, oe_lsb}, 2);
      chk("R7", "msb data", data_out, 'hA50);
      bus(0, 1, 1, 0, 0); tick(6);
      cur_req = "R8";
      bus(1, 0, 1, 1, 0); tick(6);
      chk("R8", "lsb enables", {oe_msb, oe_lsb}, 1);
      chk("R8", "lsb data", data_out, 'hC00);
      cur_req = "R9";
      addr_lo = 1'b0; tick(6);
      chk("R9", "held lane", {oe_msb, oe_lsb}, 1);
      chk("R9", "held data", data_out, 'hC00);
      bus(0, 1, 1, 0, 1); tick(6);

      // Short conversion
      cur_req = "R10";
      next_res = 12'h3B7;
      bus(1, 0, 0, 1, 1); tick(3);
      bus(0, 1, 1, 0, 1); tick(20);
      chk("R2", "start count short", starts, 2);
      bus(1, 0, 1, 0, 1); tick(6);
      chk("R10", "short data", data_out, 'h3B0);
      bus(0, 1, 1, 0, 1); tick(6);

      // Commands during a long conversion
      cur_req = "R4";
      resp_lat = 24;
      next_res = 12'h111;
      bus(1, 0, 0, 0, 1); tick(5);
      chk("R3", "busy during conversion", busy, 1);
      bus(1, 1, 0, 0, 1); tick(3);
      bus(1, 0, 0, 0, 1); tick(4);
      chk("R4", "no restart mid conversion", starts, 3);
      cur_req = "R5";
      bus(1, 0, 1, 0, 1); tick(4);
      chk("R5", "enables while busy", {oe_msb, oe_lsb}, 0);
      cur_req = "R4";
      bus(1, 0, 0, 0, 1); tick(30);
      chk("R4", "held level no retrigger", starts, 3);
      chk("R4", "busy after held level", busy, 0);
      bus(0, 1, 1, 0, 1); tick(6);
      resp_lat = 6;

      // Unqualified commands
      cur_req = "R1";
      bus(1, 1, 0, 0, 1); tick(10);
      chk("R1", "deselected convert", starts, 3);
      bus(0, 0, 1, 0, 1); tick(6);
      chk("R1", "disabled read", {oe_msb, oe_lsb}, 0);
      bus(0, 1, 1, 0, 1); tick(4);

      // Stray completion while idle
      cur_req = "R12";
      seq_result = 12'hFFF; seq_done = 1'b1; tick(1); seq_done = 1'b0; tick(3);
      bus(1, 0, 1, 0, 1); tick(6);
      chk("R12", "hold unchanged", data_out, 'h111);

      // Stand-alone: low pulse
      cur_req = "R11";
      chk("R11", "standalone enabled", {oe_msb, oe_lsb}, 3);
      next_res = 12'h9C3;
      rd_cvt = 1'b0; tick(2); rd_cvt = 1'b1; tick(3);
      chk("R11", "low pulse off", {oe_msb, oe_lsb}, 0);
      chk("R11", "low pulse busy", busy, 1);
      tick(20);
      chk("R11", "low pulse back", data_out, 'h9C3);
      // Stand-alone: high pulse
      next_res = 12'h5A6;
      rd_cvt = 1'b0; tick(24);
      chk("R11", "high pulse stays off", {oe_msb, oe_lsb}, 0);
      chk("R11", "high pulse starts", starts, 5);
      rd_cvt = 1'b1; tick(6);
      chk("R11", "high pulse data", data_out, 'h5A6);
      bus(0, 1, 1, 0, 1); tick(6);

      finish_run();
   end
endmodule